// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 38-bit logical address into a physical address by walking a two-level radix page table held in memory. The logical address splits into a 12-bit directory index (bits 37:26), a 12-bit table index (bits 25:14) and a 14-bit byte offset (bits 13:0). Pages and frames are 16 KB. Every directory and every page table holds 4096 entries of 4 bytes each, so one table fills exactly one frame.

The walker takes one request at a time, along with the physical base of the directory. It fetches the directory entry and then the leaf entry through a read port that has a request/response handshake and any latency. It checks the flags of each entry and ends with a one-cycle completion pulse. That pulse carries either the physical address or a fault code and the level that failed. It does not write entries back. It only reports the accessed and dirty flags of the leaf entry.

Entry layout, 32 bits: frame number in bits 31:8. Flags: present in bit 0, writable in bit 1, user-accessible in bit 2, accessed in bit 3, dirty in bit 4. Bits 7:5 are reserved and ignored.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `done` and `mem_req_valid` are 0.
- R2: The first memory read goes to `dir_base + dir_index*4`, where dir_index is vaddr[37:26].
- R3: The second memory read goes to `{dir_frame, 14'b0} + table_index*4`. Here dir_frame is bits 31:8 of the directory entry and table_index is vaddr[25:14].
- R4: A walk with no fault makes exactly two reads and ends with `fault_code`=0 and `phys_addr` = {leaf frame, vaddr[13:0]}.
- R5: A directory entry with bit 0 clear ends the walk after one read with `fault_code`=1 (not present) and `fault_level`=0. Not-present wins over any protection violation.
- R6: A leaf entry with bit 0 clear ends the walk with `fault_code`=1 and `fault_level`=1.
- R7: A write request (`req_write`=1) that meets an entry with bit 1 clear, at either level, ends with `fault_code`=2 (protection) at that level, and `phys_addr` is 0. A read of the same page succeeds.
- R8: A user-mode request (`req_user`=1) that meets an entry with bit 2 clear ends with `fault_code`=2. A supervisor request to the same page succeeds.
- R9: `req_ready` is low from the cycle after a request is accepted until the cycle after `done`. `done` lasts exactly one cycle. Requests presented while the walker is busy have no effect.
- R10: `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is seen. Results do not depend on the stall length or the response latency.
- R11: On success, `leaf_accessed` and `leaf_dirty` show bits 3 and 4 of the leaf entry. Reserved bits 7:5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 38 | Logical address to translate |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user mode |
| dir_base | input | 38 | Physical base of the directory, sampled on accept |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 38 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 2 | 0 none, 1 not present, 2 protection |
| fault_level | output | 1 | 0 directory, 1 leaf table (valid on fault) |
| phys_addr | output | 38 | Translated address, 0 on fault |
| leaf_accessed | output | 1 | Leaf accessed flag on success |
| leaf_dirty | output | 1 | Leaf dirty flag on success |

## Verification
The hardest condition to reach from the ports is a new request that arrives while a walk is still in progress. To create it, one scenario holds `req_valid` high with a different address for the whole walk. It then checks that the result still matches the first address and that exactly two reads were issued. A second hard case is a protection fault at the directory level rather than the leaf level. The bench sets this up with a directory entry that is present but read-only, and checks that the walk stops after a single read. Stall and latency knobs in the bench memory model stretch both handshakes so that the stability rule for the request is exercised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W    = 38;
    localparam int OFF_W   = 14;
    localparam int IDX_W   = 12;
    localparam int ENT_W   = 32;
    localparam int FLAG_W  = 8;
    localparam int FRM_W   = ENT_W - FLAG_W;
    localparam int PA_W    = FRM_W + OFF_W;
    localparam int ENT_SH  = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ_DIR, ST_WAIT_DIR, ST_READ_PTE, ST_WAIT_PTE, ST_DONE, ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_e;

    typedef struct packed {
        logic [FRM_W-1:0] frame;
        logic [2:0]       rsvd;
        logic             dirty;
        logic             accessed;
        logic             user;
        logic             writable;
        logic             present;
    } entry_t;

    typedef struct packed {
        logic [VA_W-1:0] vaddr;
        logic            wr;
        logic            usr;
        logic [PA_W-1:0] base;
    } walk_req_t;

    function automatic fault_e judge_entry(entry_t e, logic wr, logic usr);
        if (!e.present)
            return FLT_ABSENT;
        else if ((wr && !e.writable) || (usr && !e.user))
            return FLT_PROT;
        else
            return FLT_NONE;
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic             pte_stage,
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [FRM_W-1:0] dir_frame,
    output logic [PA_W-1:0]  addr
);
    localparam int PAD_W = PA_W - IDX_W - ENT_SH;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;
    logic [PA_W-1:0]  dir_off;
    logic [PA_W-1:0]  tbl_off;
    logic [PA_W-1:0]  tbl_base;

    assign dir_idx  = vaddr[VA_W-1 -: IDX_W];
    assign tbl_idx  = vaddr[OFF_W +: IDX_W];
    assign dir_off  = {{PAD_W{1'b0}}, dir_idx, {ENT_SH{1'b0}}};
    assign tbl_off  = {{PAD_W{1'b0}}, tbl_idx, {ENT_SH{1'b0}}};
    assign tbl_base = {dir_frame, {OFF_W{1'b0}}};

    always_comb begin
        if (pte_stage)
            addr = tbl_base + tbl_off;
        else
            addr = base + dir_off;
    end
endmodule

// File: rtl/ptw_entry_judge.sv
module ptw_entry_judge
    import ptw_pkg::*;
(
    input  entry_t ent,
    input  logic   wr,
    input  logic   usr,
    output fault_e verdict
);
    always_comb verdict = judge_entry(ent, wr, usr);

    // R5: an absent entry is never reported as a protection fault
    always_comb begin
        if (!ent.present)
            p_absent_first_r5: assert (verdict != FLT_PROT);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic [PA_W-1:0]  dir_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    output logic             done,
    output logic [1:0]       fault_code,
    output logic             fault_level,
    output logic [PA_W-1:0]  phys_addr,
    output logic             leaf_accessed,
    output logic             leaf_dirty
);
    walk_state_e      st;
    walk_req_t        cur;
    logic [FRM_W-1:0] dir_frame;
    logic [PA_W-1:0]  pa_q;
    fault_e           code_q;
    logic             lvl_q;
    logic             acc_q;
    logic             dty_q;
    entry_t           rsp_ent;
    fault_e           verdict;
    logic [PA_W-1:0]  walk_addr;

    assign rsp_ent = entry_t'(mem_rsp_data);

    ptw_addr_gen u_addr (
        .pte_stage (st == ST_READ_PTE),
        .base      (cur.base),
        .vaddr     (cur.vaddr),
        .dir_frame (dir_frame),
        .addr      (walk_addr)
    );

    ptw_entry_judge u_judge (
        .ent     (rsp_ent),
        .wr      (cur.wr),
        .usr     (cur.usr),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cur       <= '0;
            dir_frame <= '0;
            pa_q      <= '0;
            code_q    <= FLT_NONE;
            lvl_q     <= 1'b0;
            acc_q     <= 1'b0;
            dty_q     <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur <= '{vaddr: req_vaddr, wr: req_write, usr: req_user, base: dir_base};
                        st  <= ST_READ_DIR;
                    end
                end
                ST_READ_DIR: if (mem_req_ready) st <= ST_WAIT_DIR;
                ST_WAIT_DIR: begin
                    if (mem_rsp_valid) begin
                        if (verdict != FLT_NONE) begin
                            code_q <= verdict;
                            lvl_q  <= 1'b0;
                            pa_q   <= '0;
                            acc_q  <= 1'b0;
                            dty_q  <= 1'b0;
                            st     <= ST_FAULT;
                        end else begin
                            dir_frame <= rsp_ent.frame;
                            st        <= ST_READ_PTE;
                        end
                    end
                end
                ST_READ_PTE: if (mem_req_ready) st <= ST_WAIT_PTE;
                ST_WAIT_PTE: begin
                    if (mem_rsp_valid) begin
                        if (verdict != FLT_NONE) begin
                            code_q <= verdict;
                            lvl_q  <= 1'b1;
                            pa_q   <= '0;
                            acc_q  <= 1'b0;
                            dty_q  <= 1'b0;
                            st     <= ST_FAULT;
                        end else begin
                            code_q <= FLT_NONE;
                            lvl_q  <= 1'b0;
                            pa_q   <= {rsp_ent.frame, cur.vaddr[OFF_W-1:0]};
                            acc_q  <= rsp_ent.accessed;
                            dty_q  <= rsp_ent.dirty;
                            st     <= ST_DONE;
                        end
                    end
                end
                ST_DONE, ST_FAULT: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (st == ST_IDLE);
    assign mem_req_valid = (st == ST_READ_DIR) || (st == ST_READ_PTE);
    assign mem_req_addr  = walk_addr;
    assign done          = (st == ST_DONE) || (st == ST_FAULT);
    assign fault_code    = code_q;
    assign fault_level   = lvl_q;
    assign phys_addr     = pa_q;
    assign leaf_accessed = acc_q;
    assign leaf_dirty    = dty_q;

    // R9: one walk at a time
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid && !done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: request held until accepted
    p_hold_req_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R7: no address leaks out on a fault
    p_fault_no_pa_r7: assert property (@(posedge clk) disable iff (rst)
        done && (fault_code != 2'd0) |-> phys_addr == '0);

    // R4: the success pulse carries the requested page offset
    p_offset_kept_r4: assert property (@(posedge clk) disable iff (rst)
        done && (fault_code == 2'd0) |-> phys_addr[OFF_W-1:0] == cur.vaddr[OFF_W-1:0]);
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    import ptw_pkg::*;
    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] F_P = 8'h01, F_W = 8'h02, F_U = 8'h04, F_A = 8'h08, F_D = 8'h10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [37:0] req_vaddr = '0, dir_base = '0;
    logic req_ready, mem_req_valid, done, fault_level, leaf_accessed, leaf_dirty;
    logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [37:0] mem_req_addr, phys_addr;
    logic [1:0] fault_code;

    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault_code(fault_code), .fault_level(fault_level),
        .phys_addr(phys_addr), .leaf_accessed(leaf_accessed), .leaf_dirty(leaf_dirty)
    );

    // memory model
    logic [31:0] mem [logic [37:0]];
    int lat = 0, stall = 0, cnt = 0, gap = 0, nreads = 0;
    bit busy = 0;
    logic [37:0] pend;
    logic [37:0] raddr [0:3];

    function automatic logic [31:0] rd(logic [37:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rst) begin
            busy = 0; mem_req_ready = 1'b0; gap = 0;
        end else if (busy) begin
            mem_req_ready = 1'b0;
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(pend);
                busy = 0;
            end else cnt--;
        end else if (mem_req_valid) begin
            if (gap < stall) begin
                mem_req_ready = 1'b0;
                gap++;
            end else begin
                mem_req_ready = 1'b1;
                pend = mem_req_addr;
                if (nreads < 4) raddr[nreads] = mem_req_addr;
                nreads++;
                busy = 1; cnt = lat; gap = 0;
            end
        end else mem_req_ready = 1'b0;
    end

    function automatic logic [37:0] mkva(logic [11:0] d, logic [11:0] t, logic [13:0] o);
        return {d, t, o};
    endfunction
    function automatic logic [37:0] dir_at(logic [37:0] b, logic [11:0] d);
        return b + {24'b0, d, 2'b00};
    endfunction
    function automatic logic [37:0] pte_at(logic [23:0] fr, logic [11:0] t);
        return {fr, 14'b0} + {24'b0, t, 2'b00};
    endfunction

    task automatic expect_eq(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [37:0] got_pa;
    logic [1:0]  got_code;
    logic        got_lvl, got_acc, got_dty;
    bit          got_ok;

    task automatic do_walk(logic [37:0] va, bit wr, bit usr, bit poke);
        @(negedge clk);
        nreads = 0;
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            req_vaddr = ~va; req_write = ~wr; req_user = ~usr;
        end else req_valid = 1'b0;
        expect_eq("R9 ready low after accept", req_ready, 0);
        got_ok = 0;
        for (int i = 0; i < 400 && !got_ok; i++) begin
            if (done) begin
                got_ok = 1; got_pa = phys_addr; got_code = fault_code;
                got_lvl = fault_level; got_acc = leaf_accessed; got_dty = leaf_dirty;
            end else @(negedge clk);
        end
        req_valid = 1'b0;
        expect_eq("R9 walk completes", got_ok, 1);
        @(negedge clk);
        expect_eq("R9 done one cycle", done, 0);
        expect_eq("R9 ready after done", req_ready, 1);
    endtask

    localparam logic [37:0] BASE = 38'h00_0400_0000;

    task automatic t_reset();
        expect_eq("R1 ready", req_ready, 1);
        expect_eq("R1 done", done, 0);
        expect_eq("R1 mem_req_valid", mem_req_valid, 0);
    endtask

    task automatic t_ok();
        lat = 0; stall = 0;
        do_walk(mkva(12'h5A3, 12'h0F1, 14'h1ABC), 1'b1, 1'b1, 1'b0);
        expect_eq("R4 reads", nreads, 2);
        expect_eq("R2 dir addr", raddr[0], dir_at(BASE, 12'h5A3));
        expect_eq("R3 pte addr", raddr[1], pte_at(24'h001234, 12'h0F1));
        expect_eq("R4 code", got_code, 0);
        expect_eq("R4 pa", got_pa, {24'hABCDEF, 14'h1ABC});
        expect_eq("R11 accessed", got_acc, 1);
        expect_eq("R11 dirty", got_dty, 1);
    endtask

    task automatic t_latency();
        lat = 5; stall = 3;
        do_walk(mkva(12'hFFF, 12'h000, 14'h3FFF), 1'b0, 1'b1, 1'b0);
        expect_eq("R10 reads", nreads, 2);
        expect_eq("R10 dir addr edge", raddr[0], dir_at(BASE, 12'hFFF));
        expect_eq("R10 pte addr edge", raddr[1], pte_at(24'h000456, 12'h000));
        expect_eq("R10 code", got_code, 0);
        expect_eq("R10 pa", got_pa, {24'h00FEED, 14'h3FFF});
        expect_eq("R11 accessed clear", got_acc, 0);
        expect_eq("R11 dirty clear", got_dty, 0);
        lat = 0; stall = 0;
    endtask

    task automatic t_dir_absent();
        do_walk(mkva(12'h001, 12'h222, 14'h0010), 1'b1, 1'b1, 1'b0);
        expect_eq("R5 code absent before prot", got_code, 1);
        expect_eq("R5 level", got_lvl, 0);
        expect_eq("R5 one read", nreads, 1);
        expect_eq("R5 pa zero", got_pa, 0);
    endtask

    task automatic t_pte_absent();
        do_walk(mkva(12'h5A3, 12'h0F2, 14'h0000), 1'b0, 1'b0, 1'b0);
        expect_eq("R6 code", got_code, 1);
        expect_eq("R6 level", got_lvl, 1);
        expect_eq("R6 reads", nreads, 2);
    endtask

    task automatic t_write_prot();
        do_walk(mkva(12'h010, 12'h003, 14'h0042), 1'b1, 1'b0, 1'b0);
        expect_eq("R7 leaf code", got_code, 2);
        expect_eq("R7 leaf level", got_lvl, 1);
        expect_eq("R7 leaf pa zero", got_pa, 0);
        do_walk(mkva(12'h010, 12'h003, 14'h0042), 1'b0, 1'b0, 1'b0);
        expect_eq("R7 read ok", got_code, 0);
        expect_eq("R7 read pa", got_pa, {24'h000999, 14'h0042});
        do_walk(mkva(12'h020, 12'h004, 14'h0001), 1'b1, 1'b0, 1'b0);
        expect_eq("R7 dir code", got_code, 2);
        expect_eq("R7 dir level", got_lvl, 0);
        expect_eq("R7 dir one read", nreads, 1);
    endtask

    task automatic t_user_prot();
        do_walk(mkva(12'h5A3, 12'h0F3, 14'h0800), 1'b0, 1'b1, 1'b0);
        expect_eq("R8 user code", got_code, 2);
        expect_eq("R8 user level", got_lvl, 1);
        do_walk(mkva(12'h5A3, 12'h0F3, 14'h0800), 1'b0, 1'b0, 1'b0);
        expect_eq("R8 super ok", got_code, 0);
        expect_eq("R8 super pa", got_pa, {24'h0BEEF0, 14'h0800});
    endtask

    task automatic t_busy_poke();
        lat = 2;
        do_walk(mkva(12'h5A3, 12'h0F1, 14'h0777), 1'b0, 1'b1, 1'b1);
        expect_eq("R9 busy ignored pa", got_pa, {24'hABCDEF, 14'h0777});
        expect_eq("R9 busy ignored reads", nreads, 2);
        lat = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        dir_base = BASE;
        mem[dir_at(BASE, 12'h5A3)] = {24'h001234, F_P | F_W | F_U};
        mem[pte_at(24'h001234, 12'h0F1)] = {24'hABCDEF, 8'hE0 | F_P | F_W | F_U | F_A | F_D};
        mem[pte_at(24'h001234, 12'h0F3)] = {24'h0BEEF0, F_P | F_W};
        mem[dir_at(BASE, 12'hFFF)] = {24'h000456, F_P | F_U};
        mem[pte_at(24'h000456, 12'h000)] = {24'h00FEED, F_P | F_U};
        mem[dir_at(BASE, 12'h010)] = {24'h000777, F_P | F_W | F_U};
        mem[pte_at(24'h000777, 12'h003)] = {24'h000999, F_P | F_U};
        mem[dir_at(BASE, 12'h020)] = {24'h000888, F_P | F_U};
        mem[pte_at(24'h000888, 12'h004)] = {24'h000AAA, F_P | F_W | F_U};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ok();
        t_latency();
        t_dir_absent();
        t_pte_absent();
        t_write_prot();
        t_user_prot();
        t_busy_poke();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule